// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block is a single-level, direct-mapped cache between a byte-addressed processor port and a block-wide main memory port. It holds 256 lines of 16 bytes for a 24-bit address space. Every line keeps a stored tag, a valid flag and a dirty flag next to its 128-bit data word. Each stored tag holds only the upper address bits. The line index supplies the rest of the block number, so a victim's memory address is the stored tag with the index appended to it.

The processor raises `req_i` for one cycle with the address, the direction and the write byte. The block captures these values and looks up the indexed line in the next cycle. A hit completes with no memory traffic. A miss runs a fixed sequence: a dirty victim is written back first, then the line is refilled as one 128-bit block, and then the original read or write is carried out. Reads and writes both allocate. Completion is signalled by a one-cycle `done_o`, and `rdata_o` is valid in that same cycle.

Top module: `dmc_cache`

## Requirements
- R1: The address is split into a tag (bits 23..12), a line index (bits 11..4) and a byte offset (bits 3..0). A refill requests block number addr[23:4]; for example, address 0xAB7129 refills block 0xAB712.
- R2: A write-back presents the block number {stored tag, line index} together with the full 128-bit line. Byte k of the line sits in bits [8k+7:8k].
- R3: When the indexed line is invalid, the block refills with no write-back.
- R4: When the line is valid and its stored tag equals the address tag, the access completes without any memory request.
- R5: On a tag mismatch against a clean valid line, the block refills with no write-back.
- R6: On a tag mismatch against a dirty line, the old block is written back before the new block is requested.
- R7: After a refill the line is valid and clean. A read returns the refilled byte, and a later conflict on that line causes no write-back unless it has been written.
- R8: A write hit updates only the addressed byte and marks the line dirty, with no memory request.
- R9: A write miss refills the block and then merges the written byte, leaving the line dirty.
- R10: `stall_o` is low for hits. On a miss it rises the cycle after lookup and stays high through the completion cycle. `mem_req_o` implies `stall_o`. While `mem_ack_i` is low, `mem_req_o`, `mem_we_o` and `mem_addr_o` hold steady.
- R11: After reset every line is invalid, and `stall_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle, taken only while idle |
| we_i | input | 1 | 1 = write byte, 0 = read byte |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid while done_o is high |
| done_o | output | 1 | Access complete (one cycle) |
| stall_o | output | 1 | Miss in progress |
| mem_req_o | output | 1 | Block transfer request |
| mem_we_o | output | 1 | 1 = write-back, 0 = refill |
| mem_addr_o | output | 20 | Block number |
| mem_wdata_o | output | 128 | Write-back line |
| mem_rdata_i | input | 128 | Refill line, sampled with mem_ack_i |
| mem_ack_i | input | 1 | Transfer complete |

## Verification
Accesses are issued against one line index, 0x12, with changing tags. This separates cold refills, hits, clean-victim refills and dirty-victim write-backs. Each step predicts exactly which block transfers appear, in what order, and with which address and data. A round trip writes a byte, evicts it, and then reads it back through a fresh refill; it fails if the write-back carries the wrong data or the wrong block number. A sweep across many lines uses offsets 0 and 15 and is then evicted by a second tag. This exposes index or offset slicing errors and lost dirty flags.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WB,
    ST_FILL,
    ST_DONE
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int TAG_W = 12,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             set_dirty_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_dirty_i |=> valid_o) else $error("dirty line not valid"); // R8
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                            clk_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [OFF_W-1:0]                off_i,
  input  logic                            fill_i,
  input  logic [(DATA_W<<OFF_W)-1:0]      fill_line_i,
  input  logic                            byte_we_i,
  input  logic [DATA_W-1:0]               byte_i,
  output logic [(DATA_W<<OFF_W)-1:0]      line_o,
  output logic [DATA_W-1:0]               byte_o
);
  localparam int LINES  = 1 << IDX_W;
  localparam int NBYTES = 1 << OFF_W;
  localparam int LINE_W = DATA_W * NBYTES;

  logic [LINE_W-1:0] mem_q [LINES];
  logic [LINE_W-1:0] line_d;

  assign line_o = mem_q[idx_i];
  assign byte_o = line_o[off_i*DATA_W +: DATA_W];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_comb begin
      if (fill_i)
        line_d[b*DATA_W +: DATA_W] = fill_line_i[b*DATA_W +: DATA_W];
      else if (byte_we_i && (off_i == OFF_W'(b)))
        line_d[b*DATA_W +: DATA_W] = byte_i;
      else
        line_d[b*DATA_W +: DATA_W] = line_o[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i || byte_we_i) mem_q[idx_i] <= line_d;
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0] tag_i,
  input  logic                        valid_i,
  input  logic                        dirty_i,
  output logic [IDX_W-1:0]            idx_o,
  output logic [OFF_W-1:0]            off_o,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag_o,
  output logic                        fill_o,
  output logic                        set_dirty_o,
  output logic                        byte_we_o,
  output logic [DATA_W-1:0]           byte_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-OFF_W-1:0]     mem_addr_o,
  input  logic                        mem_ack_i,
  output logic                        stall_o,
  output logic                        done_o
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  dmc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              miss_q;
  logic              hit;

  assign idx_o      = addr_q[OFF_W +: IDX_W];
  assign off_o      = addr_q[OFF_W-1:0];
  assign fill_tag_o = addr_q[ADDR_W-1 -: TAG_W];
  assign hit        = valid_i && (tag_i == fill_tag_o);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (hit)                    st_d = ST_DONE;
        else if (valid_i && dirty_i) st_d = ST_WB;
        else                        st_d = ST_FILL;
      end
      ST_WB:    if (mem_ack_i) st_d = ST_FILL;
      ST_FILL:  if (mem_ack_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
      if (st_q == ST_CHECK) miss_q <= !hit;
      else if (st_q == ST_DONE) miss_q <= 1'b0;
    end
  end

  assign fill_o      = (st_q == ST_FILL) && mem_ack_i;
  assign byte_we_o   = (st_q == ST_DONE) && we_q;
  assign set_dirty_o = byte_we_o;
  assign byte_o      = wdata_q;
  assign done_o      = (st_q == ST_DONE);
  assign mem_req_o   = (st_q == ST_WB) || (st_q == ST_FILL);
  assign mem_we_o    = (st_q == ST_WB);
  // victim block number rebuilt from stored tag plus index
  assign mem_addr_o  = (st_q == ST_WB) ? {tag_i, idx_o} : addr_q[ADDR_W-1:OFF_W];
  assign stall_o     = (st_q == ST_WB) || (st_q == ST_FILL) || ((st_q == ST_DONE) && miss_q);

  AST_MEM_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> stall_o) else $error("memory request without stall"); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)))
    else $error("memory request dropped or changed before ack"); // R10
  AST_CLEAN_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_CHECK) && !(valid_i && dirty_i)) |=> !mem_we_o)
    else $error("write-back of clean or invalid line"); // R5
  AST_FILL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> (valid_i && !dirty_i && (tag_i == fill_tag_o)))
    else $error("refilled line not valid and clean"); // R7
  AST_WRITE_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_we_o |=> dirty_i) else $error("written line not dirty"); // R8
  AST_WB_BEFORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o))
    else $error("write-back not followed by refill"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R4
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = DATA_W << OFF_W,
  localparam int BLK_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [TAG_W-1:0]  fill_tag, tag_rd;
  logic              fill, set_dirty, byte_we, valid_rd, dirty_rd;
  logic [DATA_W-1:0] wbyte;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .tag_i       (tag_rd),
    .valid_i     (valid_rd),
    .dirty_i     (dirty_rd),
    .idx_o       (idx),
    .off_o       (off),
    .fill_tag_o  (fill_tag),
    .fill_o      (fill),
    .set_dirty_o (set_dirty),
    .byte_we_o   (byte_we),
    .byte_o      (wbyte),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .stall_o     (stall_o),
    .done_o      (done_o)
  );

  dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .fill_i      (fill),
    .fill_tag_i  (fill_tag),
    .set_dirty_i (set_dirty),
    .tag_o       (tag_rd),
    .valid_o     (valid_rd),
    .dirty_o     (dirty_rd)
  );

  dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .idx_i       (idx),
    .off_i       (off),
    .fill_i      (fill),
    .fill_line_i (mem_rdata_i),
    .byte_we_i   (byte_we),
    .byte_i      (wbyte),
    .line_o      (mem_wdata_o),
    .byte_o      (rdata_o)
  );
endmodule

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0;
  logic [23:0]  addr_i = '0;
  logic [7:0]   wdata_i = '0;
  logic [7:0]   rdata_o;
  logic         done_o, stall_o, mem_req_o, mem_we_o;
  logic [19:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic [127:0] mem_rdata_i;
  logic         mem_ack_i;

  always #2.5 clk = ~clk;

  dmc_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .stall_o(stall_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  typedef struct { bit we; bit [19:0] blk; bit [127:0] data; string rq; } txn_t;
  typedef struct { bit [7:0] v; string rq; } rd_t;

  txn_t exp_txn[$];
  rd_t  exp_rd[$];
  bit [127:0] bmem [int];
  bit [127:0] cview [int];
  bit         rv [256];
  bit         rd [256];
  bit [11:0]  rt [256];
  bit         cur_we;
  int         n_run = 0, n_fail = 0;
  bit         ended = 0;

  function automatic bit [127:0] init_blk(bit [19:0] b);
    bit [127:0] r;
    for (int k = 0; k < 16; k++) r[k*8 +: 8] = 8'(b[7:0] + 3*b[15:8] + 5*b[19:16] + 7*k + 1);
    return r;
  endfunction
  function automatic bit [127:0] get_bmem(bit [19:0] b);
    return bmem.exists(int'(b)) ? bmem[int'(b)] : init_blk(b);
  endfunction
  function automatic bit [127:0] get_cview(bit [19:0] b);
    return cview.exists(int'(b)) ? cview[int'(b)] : init_blk(b);
  endfunction

  task automatic check(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // memory responder: two-cycle latency, compares against expected transfers
  initial begin
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (rst_n && mem_req_o) begin
        repeat (2) @(negedge clk);
        if (exp_txn.size() == 0) begin
          check(0, "R4", "unexpected memory request", {mem_we_o, mem_addr_o}, 0);
        end else begin
          txn_t e;
          e = exp_txn.pop_front();
          check(mem_we_o == e.we, e.rq, "transfer direction", mem_we_o, e.we);
          check(mem_addr_o == e.blk, e.rq, "transfer block", mem_addr_o, e.blk);
          if (e.we) check(mem_wdata_o == e.data, e.rq, "write-back line", mem_wdata_o, e.data);
        end
        if (mem_we_o) bmem[int'(mem_addr_o)] = mem_wdata_o;
        else          mem_rdata_i = get_bmem(mem_addr_o);
        mem_ack_i = 1'b1;
      end
    end
  end

  // monitor: compares read results as they complete
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o && !cur_we) begin
        if (exp_rd.size() == 0) check(0, "R4", "unexpected read completion", rdata_o, 0);
        else begin
          rd_t e;
          e = exp_rd.pop_front();
          check(rdata_o == e.v, e.rq, "read data", rdata_o, e.v);
        end
      end
    end
  end

  task automatic do_access(bit we, bit [23:0] a, bit [7:0] d, string rq);
    bit [7:0]  idx = a[11:4];
    bit [11:0] tg  = a[23:12];
    bit [19:0] blk = a[23:4];
    bit        miss = !(rv[idx] && rt[idx] == tg);
    bit        saw_stall = 0;
    bit [127:0] line;
    if (miss) begin
      if (rv[idx] && rd[idx]) begin
        txn_t w;
        w.we = 1; w.blk = {rt[idx], idx}; w.data = get_cview({rt[idx], idx}); w.rq = rq;
        exp_txn.push_back(w);
      end
      begin
        txn_t f;
        f.we = 0; f.blk = blk; f.data = '0; f.rq = rq;
        exp_txn.push_back(f);
      end
      rv[idx] = 1; rt[idx] = tg; rd[idx] = 0;
    end
    line = get_cview(blk);
    if (we) begin
      line[a[3:0]*8 +: 8] = d;
      cview[int'(blk)] = line;
      rd[idx] = 1;
    end else begin
      rd_t r;
      r.v = line[a[3:0]*8 +: 8]; r.rq = rq;
      exp_rd.push_back(r);
    end
    cur_we = we;
    req_i = 1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0;
    while (!done_o) begin
      if (stall_o) saw_stall = 1;
      @(negedge clk);
    end
    if (stall_o) saw_stall = 1;
    check(saw_stall == miss, "R10", "stall seen on miss", saw_stall, miss);
    @(negedge clk);
    check(exp_txn.size() == 0, rq, "pending memory transfers", exp_txn.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin rv[i] = 0; rd[i] = 0; rt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall_o && !done_o && !mem_req_o, "R11", "outputs after reset",
          {stall_o, done_o, mem_req_o}, 0);

    do_access(0, 24'hAB7129, 8'h00, "R1");   // cold line: refill block 0xAB712 (also R3)
    do_access(0, 24'hAB7123, 8'h00, "R4");   // hit
    do_access(1, 24'hAB712C, 8'h5A, "R8");   // write hit, no memory traffic
    do_access(0, 24'hAB712C, 8'h00, "R8");   // merged byte read back
    do_access(0, 24'h895123, 8'h00, "R6");   // dirty victim: write-back then refill (R2)
    do_access(0, 24'hAB7120, 8'h00, "R5");   // clean victim after refill (R7)
    do_access(1, 24'hCD4128, 8'hC3, "R9");   // write miss allocates
    do_access(0, 24'hCD4128, 8'h00, "R9");
    do_access(0, 24'hAB712C, 8'h00, "R2");   // evicts dirty CD412, refills written-back AB712
    do_access(0, 24'hCD412F, 8'h00, "R7");   // clean victim, refill from written-back data

    for (int i = 0; i < 24; i++)
      do_access(1, {4'(i), 8'(i*13 + 1), (i % 2) ? 4'hF : 4'h0, 8'h00} >> 8, 8'(i*11 + 3), "R1");
    for (int i = 0; i < 24; i++)
      do_access(0, {4'(i), 8'(i*13 + 1), (i % 2) ? 4'hF : 4'h0, 8'h00} >> 8, 8'h00, "R4");
    for (int i = 0; i < 24; i++)
      do_access(0, {4'(i + 7), 8'(i*13 + 1), 4'h3, 8'h00} >> 8, 8'h00, "R6");
    for (int i = 0; i < 24; i++)
      do_access(0, {4'(i), 8'(i*13 + 1), (i % 2) ? 4'hF : 4'h0, 8'h00} >> 8, 8'h00, "R2");

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule